// File: doc/BRIEF.md
# Reset Cause Status Tracker

This block records why a small processor core last restarted or left a low-power state. It holds a sticky 8-bit status word that software reads and writes. The word marks the cause of the last restart, the sleep and time-out conditions, the two stack-fault conditions and the software brown-out enable. It also tells the core where to resume. A true reset sends the core to address zero. A wake from a low-power state resumes two bytes past the current program counter, or jumps to an interrupt vector when an interrupt priority level is enabled.

Each event input is a one-cycle strobe. The external master-clear and watchdog strobes are qualified by the current power mode. Each source changes only its own subset of the flags and leaves the rest as they were. When several strobes arrive in the same cycle, a fixed priority picks one of them. All outputs are registered, so the effect of an event shows at the ports one clock after its strobe.

Top module: `rst_cause_tracker`

## Requirements
- R1: The status word has this layout: bit7 soft-brown-out enable, bit6 stack underflow, bit5 stack full, bit4 restart-by-instruction (ri), bit3 time-out (to), bit2 power-down (pd), bit1 power-on-not (por_n), bit0 brown-out-not (bor_n). Power-on, and the synchronous reset input, set bits 4..0 to 1,1,1,0,0 and clear bits 6..5.
- R2: Brown-out sets ri, to and pd, clears bor_n, and leaves por_n and both stack flags unchanged.
- R3: The software reset strobe clears ri and leaves bits 3..0 and both stack flags unchanged.
- R4: The mode input is 0 for full-power run, 1 for low-power run, and 2 or 3 for idle/sleep. Master-clear changes no flag in mode 0, sets to in mode 1, and sets to and clears pd in modes 2 and 3. It is a true reset in every mode.
- R5: A watchdog time-out in mode 0 or 1 clears to and is a true reset.
- R6: A watchdog time-out in mode 2 or 3 clears to and pd. It does not reset the core, and it loads current PC + 2 as the restart address.
- R7: An interrupt wake clears pd and loads a restart address: 0x008 if the high-priority enable is set, else 0x018 if the low-priority enable is set, else current PC + 2. It is not a reset.
- R8: Stack full sets bit5 and stack underflow sets bit6. Each is a true reset only while the stack-reset enable is 1. With the enable at 0, the flag is set and no restart address is loaded.
- R9: On a true reset, bit7 becomes 1 on power-on, keeps its value otherwise, when software brown-out control is configured. Without that configuration, every true reset clears it. Non-reset events leave it unchanged.
- R10: Same-cycle priority, highest first: power-on, brown-out, master-clear, watchdog, stack full, stack underflow, software reset, interrupt wake. Only the winner takes effect.
- R11: A software write loads all eight bits when no event arrives in that cycle. A write in the same cycle as an event is discarded.
- R12: Every true reset pulses the core-reset output high for one cycle, raises the load strobe and presents restart address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset, gives the power-on status |
| ev_por_i | input | 1 | Power-on strobe |
| ev_bor_i | input | 1 | Brown-out strobe |
| ev_swrst_i | input | 1 | Software reset instruction strobe |
| ev_mclr_i | input | 1 | External master-clear strobe |
| ev_wdt_i | input | 1 | Watchdog time-out strobe |
| ev_stk_full_i | input | 1 | Stack full strobe |
| ev_stk_unf_i | input | 1 | Stack underflow strobe |
| ev_wake_i | input | 1 | Interrupt wake strobe |
| pwr_mode_i | input | 2 | Power mode qualifier |
| stk_rst_en_i | input | 1 | Stack faults cause a reset |
| int_hi_en_i | input | 1 | High-priority interrupt enable |
| int_lo_en_i | input | 1 | Low-priority interrupt enable |
| cfg_sw_bor_i | input | 1 | Software brown-out control configured |
| cur_pc_i | input | PC_W | Current program counter |
| sw_wr_i | input | 1 | Software write strobe for the status word |
| sw_wdata_i | input | 8 | Software write data |
| status_o | output | 8 | Status word (software read) |
| core_rst_o | output | 1 | One-cycle core reset request |
| pc_load_o | output | 1 | Restart address valid strobe |
| restart_pc_o | output | PC_W | Restart address |

## Verification
A wrong internal flag update shows on status_o one clock after the strobe and stays there until a later event or write, so a single readback after each event finds it. A wrong choice among reset, resume and vector shows in the same cycle on core_rst_o, pc_load_o and restart_pc_o. Priority faults only show when strobes coincide, so those cases are driven on purpose. An event that should leave a bit alone is checked by starting from a known word that holds the opposite value in that bit.

// File: rtl/rct_pkg.sv
// Package: shared types for the reset cause tracker.
// Assumes event codes are consecutive in priority order starting at 1.
package rct_pkg;

    localparam int NUM_SRC = 8;

    typedef enum logic [3:0] {
        EV_NONE = 4'd0,
        EV_POR  = 4'd1,
        EV_BOR  = 4'd2,
        EV_MCLR = 4'd3,
        EV_WDT  = 4'd4,
        EV_STKF = 4'd5,
        EV_STKU = 4'd6,
        EV_SWR  = 4'd7,
        EV_WAKE = 4'd8
    } rct_event_e;

    typedef struct packed {
        logic sbor_en;
        logic stk_unf;
        logic stk_full;
        logic ri;
        logic to;
        logic pd;
        logic por_n;
        logic bor_n;
    } rct_flags_t;

    // Power-on value of the status word; sbor_en is filled in from configuration
    function automatic rct_flags_t por_flags(input logic cfg_sw_bor);
        rct_flags_t f;
        f.sbor_en  = cfg_sw_bor;
        f.stk_unf  = 1'b0;
        f.stk_full = 1'b0;
        f.ri       = 1'b1;
        f.to       = 1'b1;
        f.pd       = 1'b1;
        f.por_n    = 1'b0;
        f.bor_n    = 1'b0;
        return f;
    endfunction

endpackage

// File: rtl/rct_event_arbiter.sv
// Module: picks the single highest-priority event among same-cycle strobes.
// Assumes the request vector is ordered with index 0 as the highest priority.
module rct_event_arbiter
    import rct_pkg::*;
#(
    parameter int N_SRC = NUM_SRC
) (
    input  logic [N_SRC-1:0] req_i,
    output rct_event_e       winner_o
);

    // Priority scan: lower index overrides higher index
    always_comb begin
        winner_o = EV_NONE;
        for (int i = N_SRC - 1; i >= 0; i--) begin
            if (req_i[i]) begin
                winner_o = rct_event_e'(4'(i + 1));
            end
        end
    end

endmodule

// File: rtl/rct_flag_next.sv
// Module: next status word and action class for the winning event.
// Assumes one event per cycle (already arbitrated); EV_NONE keeps the word.
module rct_flag_next
    import rct_pkg::*;
(
    input  rct_event_e  ev_i,
    input  rct_flags_t  cur_i,
    input  logic [1:0]  mode_i,
    input  logic        stk_rst_en_i,
    input  logic        cfg_sw_bor_i,
    output rct_flags_t  nxt_o,
    output logic        do_reset_o,
    output logic        do_resume_o,
    output logic        allow_vec_o
);

    logic idle_mode;
    logic lp_run_mode;
    rct_flags_t upd;

    assign idle_mode   = mode_i[1];
    assign lp_run_mode = (mode_i == 2'd1);

    // Per-source flag update and action class
    always_comb begin
        upd         = cur_i;
        do_reset_o  = 1'b0;
        do_resume_o = 1'b0;
        allow_vec_o = 1'b0;
        unique case (ev_i)
            EV_POR: begin
                upd        = por_flags(cfg_sw_bor_i);
                do_reset_o = 1'b1;
            end
            EV_BOR: begin
                upd.ri     = 1'b1;
                upd.to     = 1'b1;
                upd.pd     = 1'b1;
                upd.bor_n  = 1'b0;
                do_reset_o = 1'b1;
            end
            EV_MCLR: begin
                if (idle_mode) begin
                    upd.to = 1'b1;
                    upd.pd = 1'b0;
                end else if (lp_run_mode) begin
                    upd.to = 1'b1;
                end
                do_reset_o = 1'b1;
            end
            EV_WDT: begin
                upd.to = 1'b0;
                if (idle_mode) begin
                    upd.pd      = 1'b0;
                    do_resume_o = 1'b1;
                end else begin
                    do_reset_o  = 1'b1;
                end
            end
            EV_STKF: begin
                upd.stk_full = 1'b1;
                do_reset_o   = stk_rst_en_i;
            end
            EV_STKU: begin
                upd.stk_unf = 1'b1;
                do_reset_o  = stk_rst_en_i;
            end
            EV_SWR: begin
                upd.ri     = 1'b0;
                do_reset_o = 1'b1;
            end
            EV_WAKE: begin
                upd.pd      = 1'b0;
                do_resume_o = 1'b1;
                allow_vec_o = 1'b1;
            end
            default: begin
                upd = cur_i;
            end
        endcase
    end

    // Soft brown-out enable rule applied on every true reset except power-on
    always_comb begin
        nxt_o = upd;
        if (do_reset_o && (ev_i != EV_POR) && !cfg_sw_bor_i) begin
            nxt_o.sbor_en = 1'b0;
        end
    end

endmodule

// File: rtl/rct_pc_select.sv
// Module: restart address selection for reset, resume and vectored wake.
// Assumes do_reset and do_resume are never both set.
module rct_pc_select #(
    parameter int          PC_W    = 21,
    parameter logic [31:0] VEC_HI  = 32'h008,
    parameter logic [31:0] VEC_LO  = 32'h018,
    parameter int          PC_STEP = 2
) (
    input  logic            do_reset_i,
    input  logic            do_resume_i,
    input  logic            allow_vec_i,
    input  logic            int_hi_en_i,
    input  logic            int_lo_en_i,
    input  logic [PC_W-1:0] cur_pc_i,
    output logic            load_o,
    output logic [PC_W-1:0] pc_o
);

    localparam logic [PC_W-1:0] PC_HI   = VEC_HI[PC_W-1:0];
    localparam logic [PC_W-1:0] PC_LO   = VEC_LO[PC_W-1:0];
    localparam logic [PC_W-1:0] PC_INC  = PC_W'(PC_STEP);

    assign load_o = do_reset_i | do_resume_i;

    // Address mux: zero for reset, vector or next instruction for resume
    always_comb begin
        pc_o = '0;
        if (do_resume_i) begin
            if (allow_vec_i && int_hi_en_i) begin
                pc_o = PC_HI;
            end else if (allow_vec_i && int_lo_en_i) begin
                pc_o = PC_LO;
            end else begin
                pc_o = cur_pc_i + PC_INC;
            end
        end
    end

endmodule

// File: rtl/rst_cause_tracker.sv
// Module: top of the reset cause tracker. Arbitrates event strobes, updates the
// sticky status word, and registers the core reset and restart address.
// Assumes event strobes are one cycle wide and synchronous to clk.
module rst_cause_tracker
    import rct_pkg::*;
#(
    parameter int          PC_W    = 21,
    parameter logic [31:0] VEC_HI  = 32'h008,
    parameter logic [31:0] VEC_LO  = 32'h018,
    parameter int          PC_STEP = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ev_por_i,
    input  logic            ev_bor_i,
    input  logic            ev_swrst_i,
    input  logic            ev_mclr_i,
    input  logic            ev_wdt_i,
    input  logic            ev_stk_full_i,
    input  logic            ev_stk_unf_i,
    input  logic            ev_wake_i,
    input  logic [1:0]      pwr_mode_i,
    input  logic            stk_rst_en_i,
    input  logic            int_hi_en_i,
    input  logic            int_lo_en_i,
    input  logic            cfg_sw_bor_i,
    input  logic [PC_W-1:0] cur_pc_i,
    input  logic            sw_wr_i,
    input  logic [7:0]      sw_wdata_i,
    output logic [7:0]      status_o,
    output logic            core_rst_o,
    output logic            pc_load_o,
    output logic [PC_W-1:0] restart_pc_o
);

    logic [NUM_SRC-1:0] req;
    rct_event_e         winner;
    rct_flags_t         flags_q;
    rct_flags_t         flags_nxt;
    logic               do_reset;
    logic               do_resume;
    logic               allow_vec;
    logic               pc_ld;
    logic [PC_W-1:0]    pc_nxt;
    logic               rst_q;
    logic               ld_q;
    logic [PC_W-1:0]    pc_q;

    // Request vector in priority order, index 0 highest
    assign req = {ev_wake_i, ev_swrst_i, ev_stk_unf_i, ev_stk_full_i,
                  ev_wdt_i, ev_mclr_i, ev_bor_i, ev_por_i};

    rct_event_arbiter #(.N_SRC(NUM_SRC)) arb_i (
        .req_i    (req),
        .winner_o (winner)
    );

    rct_flag_next flag_i (
        .ev_i         (winner),
        .cur_i        (flags_q),
        .mode_i       (pwr_mode_i),
        .stk_rst_en_i (stk_rst_en_i),
        .cfg_sw_bor_i (cfg_sw_bor_i),
        .nxt_o        (flags_nxt),
        .do_reset_o   (do_reset),
        .do_resume_o  (do_resume),
        .allow_vec_o  (allow_vec)
    );

    rct_pc_select #(
        .PC_W    (PC_W),
        .VEC_HI  (VEC_HI),
        .VEC_LO  (VEC_LO),
        .PC_STEP (PC_STEP)
    ) pcs_i (
        .do_reset_i  (do_reset),
        .do_resume_i (do_resume),
        .allow_vec_i (allow_vec),
        .int_hi_en_i (int_hi_en_i),
        .int_lo_en_i (int_lo_en_i),
        .cur_pc_i    (cur_pc_i),
        .load_o      (pc_ld),
        .pc_o        (pc_nxt)
    );

    // Status word: hardware event wins over a software write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q <= por_flags(cfg_sw_bor_i);
        end else if (winner != EV_NONE) begin
            flags_q <= flags_nxt;
        end else if (sw_wr_i) begin
            flags_q <= rct_flags_t'(sw_wdata_i);
        end
    end

    // Registered core reset request and restart address
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rst_q <= 1'b0;
            ld_q  <= 1'b0;
            pc_q  <= '0;
        end else begin
            rst_q <= do_reset;
            ld_q  <= pc_ld;
            if (pc_ld) begin
                pc_q <= pc_nxt;
            end
        end
    end

    assign status_o     = flags_q;
    assign core_rst_o   = rst_q;
    assign pc_load_o    = ld_q;
    assign restart_pc_o = pc_q;

    AST_POR_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        ev_por_i |=> (status_o[6:0] == 7'b0011100)); // R1

    AST_SWR_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (winner == EV_SWR) |=> (!status_o[4] && status_o[3:0] == $past(status_o[3:0]))); // R3

    AST_WDT_IDLE_RESUME: assert property (@(posedge clk) disable iff (!rst_n)
        (winner == EV_WDT && pwr_mode_i[1]) |=> (!core_rst_o && pc_load_o && !status_o[3] && !status_o[2])); // R6

    AST_WAKE_NO_RST: assert property (@(posedge clk) disable iff (!rst_n)
        (winner == EV_WAKE) |=> (!core_rst_o && pc_load_o && !status_o[2])); // R7

    AST_RST_PC_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        core_rst_o |-> (pc_load_o && restart_pc_o == '0)); // R12

    AST_IDLE_NO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (req == '0) |=> (!core_rst_o && !pc_load_o)); // R12

    AST_SW_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (req == '0 && sw_wr_i) |=> (status_o == $past(sw_wdata_i))); // R11

    AST_ONE_WINNER: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_por_i && ev_bor_i) |-> (winner == EV_POR)); // R10

endmodule

// File: tb/rst_cause_tracker_tb_top.sv
module rst_cause_tracker_tb_top;

    localparam int PC_W       = 21;
    localparam int CLK_PERIOD = 10;
    localparam int N_VEC      = 18;
    localparam logic [PC_W-1:0] CUR_PC = 21'h001234;

    // {start8, ev4, mode2, stk_en, hi, lo, cfg, exp8, exp_rst, exp_ld, exp_pc16}
    // ev: 1 por, 2 bor, 3 swr, 4 mclr, 5 wdt, 6 stk full, 7 stk unf, 8 wake
    localparam logic [43:0] VEC [N_VEC] = '{
        {8'h00, 4'd1, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 8'h9C, 1'b1, 1'b1, 16'h0000}, // R1 R9
        {8'hFF, 4'd1, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h1C, 1'b1, 1'b1, 16'h0000}, // R1 R9
        {8'h02, 4'd2, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 8'h1E, 1'b1, 1'b1, 16'h0000}, // R2
        {8'hE3, 4'd2, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h7E, 1'b1, 1'b1, 16'h0000}, // R2 R9
        {8'hFF, 4'd3, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 8'hEF, 1'b1, 1'b1, 16'h0000}, // R3
        {8'h80, 4'd4, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 8'h80, 1'b1, 1'b1, 16'h0000}, // R4
        {8'h00, 4'd4, 2'd1, 1'b0, 1'b0, 1'b0, 1'b1, 8'h08, 1'b1, 1'b1, 16'h0000}, // R4
        {8'h04, 4'd4, 2'd2, 1'b0, 1'b0, 1'b0, 1'b1, 8'h08, 1'b1, 1'b1, 16'h0000}, // R4
        {8'hFF, 4'd5, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 8'hF7, 1'b1, 1'b1, 16'h0000}, // R5
        {8'h8C, 4'd5, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h04, 1'b1, 1'b1, 16'h0000}, // R5 R9
        {8'h8C, 4'd5, 2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 8'h80, 1'b0, 1'b1, 16'h1236}, // R6 R9
        {8'h00, 4'd6, 2'd0, 1'b1, 1'b0, 1'b0, 1'b1, 8'h20, 1'b1, 1'b1, 16'h0000}, // R8
        {8'h80, 4'd7, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 8'h40, 1'b1, 1'b1, 16'h0000}, // R8 R9
        {8'h80, 4'd7, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 8'hC0, 1'b0, 1'b0, 16'h0000}, // R8
        {8'h04, 4'd8, 2'd2, 1'b0, 1'b1, 1'b1, 1'b1, 8'h00, 1'b0, 1'b1, 16'h0008}, // R7
        {8'h04, 4'd8, 2'd2, 1'b0, 1'b0, 1'b1, 1'b1, 8'h00, 1'b0, 1'b1, 16'h0018}, // R7
        {8'h0C, 4'd8, 2'd3, 1'b0, 1'b0, 1'b0, 1'b1, 8'h08, 1'b0, 1'b1, 16'h1236}, // R7
        {8'h00, 4'd6, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 8'h20, 1'b0, 1'b0, 16'h0000}  // R8
    };

    logic clk = 1'b0;
    logic rst_n;
    logic ev_por, ev_bor, ev_swrst, ev_mclr, ev_wdt, ev_stkf, ev_stku, ev_wake;
    logic [1:0] pwr_mode;
    logic stk_en, hi_en, lo_en, cfg_sbor, sw_wr;
    logic [7:0] sw_wdata;
    logic [7:0] status;
    logic core_rst, pc_load;
    logic [PC_W-1:0] restart_pc;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    rst_cause_tracker #(.PC_W(PC_W)) dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .ev_por_i      (ev_por),
        .ev_bor_i      (ev_bor),
        .ev_swrst_i    (ev_swrst),
        .ev_mclr_i     (ev_mclr),
        .ev_wdt_i      (ev_wdt),
        .ev_stk_full_i (ev_stkf),
        .ev_stk_unf_i  (ev_stku),
        .ev_wake_i     (ev_wake),
        .pwr_mode_i    (pwr_mode),
        .stk_rst_en_i  (stk_en),
        .int_hi_en_i   (hi_en),
        .int_lo_en_i   (lo_en),
        .cfg_sw_bor_i  (cfg_sbor),
        .cur_pc_i      (CUR_PC),
        .sw_wr_i       (sw_wr),
        .sw_wdata_i    (sw_wdata),
        .status_o      (status),
        .core_rst_o    (core_rst),
        .pc_load_o     (pc_load),
        .restart_pc_o  (restart_pc)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic clear_ev();
        ev_por = 0; ev_bor = 0; ev_swrst = 0; ev_mclr = 0;
        ev_wdt = 0; ev_stkf = 0; ev_stku = 0; ev_wake = 0;
    endtask

    task automatic raise_ev(input logic [3:0] code);
        case (code)
            4'd1: ev_por   = 1;
            4'd2: ev_bor   = 1;
            4'd3: ev_swrst = 1;
            4'd4: ev_mclr  = 1;
            4'd5: ev_wdt   = 1;
            4'd6: ev_stkf  = 1;
            4'd7: ev_stku  = 1;
            4'd8: ev_wake  = 1;
            default: ;
        endcase
    endtask

    task automatic preload(input logic [7:0] v);
        @(negedge clk);
        sw_wr = 1; sw_wdata = v;
        @(negedge clk);
        sw_wr = 0;
    endtask

    // Pulse one cycle of strobes (already raised), then sample after the edge
    task automatic fire_and_check(input string req, input logic [7:0] exp_st,
                                  input bit exp_rst, input bit exp_ld, input logic [15:0] exp_pc);
        @(negedge clk);
        clear_ev();
        sw_wr = 0;
        chk(status == exp_st, req, 32'(status), 32'(exp_st));
        chk(core_rst == exp_rst, req, 32'(core_rst), 32'(exp_rst));
        chk(pc_load == exp_ld, req, 32'(pc_load), 32'(exp_ld));
        if (exp_ld) chk(restart_pc == PC_W'(exp_pc), req, 32'(restart_pc), 32'(exp_pc));
        @(negedge clk);
        chk(core_rst == 1'b0, "R12 single pulse", 32'(core_rst), 32'h0);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : main
        clear_ev();
        pwr_mode = 0; stk_en = 0; hi_en = 0; lo_en = 0;
        cfg_sbor = 1; sw_wr = 0; sw_wdata = 0;
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk(status == 8'h9C, "R1 reset status", 32'(status), 32'h9C);
        chk(core_rst == 0, "R1 reset core_rst", 32'(core_rst), 32'h0);
        chk(pc_load == 0, "R1 reset pc_load", 32'(pc_load), 32'h0);

        for (int i = 0; i < N_VEC; i++) begin
            logic [43:0] v;
            v = VEC[i];
            preload(v[43:36]);
            pwr_mode = v[31:30]; stk_en = v[29]; hi_en = v[28]; lo_en = v[27]; cfg_sbor = v[26];
            raise_ev(v[35:32]);
            fire_and_check($sformatf("vector %0d", i), v[25:18], v[17], v[16], v[15:0]);
        end
        hi_en = 0; lo_en = 0; stk_en = 0; cfg_sbor = 1; pwr_mode = 0;

        // R10 power-on beats brown-out
        preload(8'h00);
        ev_por = 1; ev_bor = 1;
        fire_and_check("R10 por over bor", 8'h9C, 1, 1, 16'h0);

        // R10 master-clear beats watchdog (low-power run)
        preload(8'h00);
        pwr_mode = 1; ev_mclr = 1; ev_wdt = 1;
        fire_and_check("R10 mclr over wdt", 8'h08, 1, 1, 16'h0);
        pwr_mode = 0;

        // R10 software reset beats interrupt wake
        preload(8'h14);
        ev_swrst = 1; ev_wake = 1;
        fire_and_check("R10 swr over wake", 8'h04, 1, 1, 16'h0);

        // R10 stack full beats stack underflow
        preload(8'h00);
        stk_en = 1; ev_stkf = 1; ev_stku = 1;
        fire_and_check("R10 full over unf", 8'h20, 1, 1, 16'h0);
        stk_en = 0;

        // R11 plain software write
        preload(8'h5A);
        chk(status == 8'h5A, "R11 write readback", 32'(status), 32'h5A);
        chk(core_rst == 0, "R11 write no reset", 32'(core_rst), 32'h0);

        // R11 event wins over same-cycle write
        preload(8'h9C);
        sw_wr = 1; sw_wdata = 8'h00; ev_wdt = 1;
        fire_and_check("R11 event over write", 8'h94, 1, 1, 16'h0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule